// File: doc/BRIEF.md
# DSP Single Data Transfer Unit

This block runs the single-operand move instructions of a DSP datapath, one instruction per clock. An instruction word whose top six bits carry the transfer opcode names one of four address pointers and one data register. It also names an addressing mode and an access kind: a load or store of a 16-bit word or a 32-bit longword. In the same cycle the block computes the effective address and drives a handshake-free memory port. At the clock edge that closes the cycle it writes back the loaded data and the updated pointer.

The block holds its own four pointers, the index register paired with each pointer, eight 32-bit data registers and two 8-bit guard registers. Word data sits in the upper half of a data register. Guard registers sign-extend when they are stored. A side load port lets the surrounding datapath set pointers and index registers. It stands in for the instruction classes that are not part of this block.

Top module: `dsp_xfer_unit`

## Requirements
- R1: An instruction is executed only when `instr_valid` is high and `instr[15:10]` is 111101; any other word causes no memory access, no register change and no illegal flag.
- R2: `instr[9:8]` selects pointer P0..P3 and `instr[7:4]` selects the data operand: codes 0-7 are data registers D0..D7, codes 8 and 9 are guard registers G0 and G1.
- R3: Mode `instr[3:2]`=00 (pre-decrement) subtracts 2 (word) or 4 (longword) from the pointer, uses the result as the address and keeps it in the pointer.
- R4: Mode 01 (indirect) uses the pointer as the address and leaves it unchanged.
- R5: Mode 10 (post-increment) uses the old pointer as the address, then adds 2 for a word or 4 for a longword.
- R6: Mode 11 (indexed post-increment) uses the old pointer as the address, then adds the index register paired with that pointer; all pointer arithmetic wraps modulo 2^32.
- R7: `instr[1:0]`=00 is a word load: Ds[31:16] takes `mem_rdata[15:0]` and Ds[15:0] becomes zero. `instr[1:0]`=01 is a word store: `mem_wdata[15:0]` carries Ds[31:16] and `mem_wdata[31:16]` is zero.
- R8: `instr[1:0]`=10 is a longword load of all 32 bits of `mem_rdata` into Ds. `instr[1:0]`=11 is a longword store of all of Ds.
- R9: A store from a guard register, of either size, puts the 8-bit guard value on `mem_wdata[7:0]` and copies its bit 7 into `mem_wdata[31:8]`. A load into a guard register keeps only `mem_rdata[7:0]`.
- R10: Ds codes 10-15 make no memory access and change no register; `illegal` is high during the cycle after such an instruction.
- R11: Every access completes in its own cycle. `mem_addr`, `mem_re`, `mem_we`, `mem_long` (1 = longword) and `mem_wdata` are valid during that cycle, `mem_rdata` is taken at its closing edge, and `mem_re` and `mem_we` are never high together.
- R12: A synchronous high `rst` clears all pointers, index registers, data and guard registers and `illegal`. `ld_we` writes `ld_val` into pointer `ld_sel[1:0]` when `ld_sel[2]`=0, or into its index register when `ld_sel[2]`=1. A pointer update made by an instruction wins over the load port in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| ld_we | input | 1 | Side load of a pointer or index register |
| ld_sel | input | 3 | Bit 2: 0 pointer, 1 index; bits 1:0: pair number |
| ld_val | input | 32 | Value for the side load |
| mem_addr | output | 32 | Effective address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_long | output | 1 | Access size, 1 = longword, 0 = word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, sampled at the end of the access cycle |
| illegal | output | 1 | Previous instruction named an unused data register code |

## Verification
A pointer that holds a wrong value shows on `mem_addr` the next time any instruction uses that pointer. This happens in the same cycle as that access, so each stimulus pattern reuses its pointers across several steps, and a wrong step size or a lost write appears within one or two instructions. A data or guard register with wrong contents stays hidden until it is stored. For this reason every load in the stimulus is followed by a store of the same register, and the stored `mem_wdata` exposes the half placement, the zeroing and the sign extension. A wrongly accepted or rejected instruction shows on the strobes in its own cycle and on `illegal` one cycle later.

// File: rtl/dsp_xfer_pkg.sv
package dsp_xfer_pkg;

  // Opcode carried in instr[15:10] by every transfer instruction.
  localparam logic [5:0] XFER_OPC  = 6'b111101;
  // Pointer select field width; the pointer count follows from it.
  localparam int         PTR_SEL_W = 2;
  localparam int         NUM_PTR   = 1 << PTR_SEL_W;

  typedef enum logic [1:0] {
    AM_PREDEC  = 2'b00,
    AM_PLAIN   = 2'b01,
    AM_POSTINC = 2'b10,
    AM_POSTIDX = 2'b11
  } amode_e;

  typedef struct packed {
    logic                 hit;      // opcode matched with valid
    logic                 legal;    // hit and operand code exists
    logic [PTR_SEL_W-1:0] psel;
    logic [3:0]           dsel;
    logic                 guard;    // operand is a guard register
    amode_e               mode;
    logic                 is_long;
    logic                 is_store;
  } xfer_dec_t;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import dsp_xfer_pkg::*;
#(
  parameter int NUM_DREG  = 8,
  parameter int NUM_GUARD = 2
) (
  input  logic      valid,
  input  logic [15:0] instr,
  output xfer_dec_t dec
);

  localparam int OPND_LIM = NUM_DREG + NUM_GUARD;

  logic [31:0] code;
  assign code = {28'd0, instr[7:4]};

  always_comb begin
    dec.hit      = valid && (instr[15:10] == XFER_OPC);
    dec.psel     = instr[8 +: PTR_SEL_W];
    dec.dsel     = instr[7:4];
    dec.mode     = amode_e'(instr[3:2]);
    dec.is_long  = instr[1];
    dec.is_store = instr[0];
    dec.guard    = (code >= 32'(NUM_DREG)) && (code < 32'(OPND_LIM));
    dec.legal    = dec.hit && (code < 32'(OPND_LIM));
  end

endmodule

// File: rtl/xfer_agu.sv
module xfer_agu
  import dsp_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  amode_e            mode,
  input  logic              is_long,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] idx,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] ptr_nxt,
  output logic              ptr_upd
);

  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_LONG = ADDR_W'(4);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] dec_ptr;

  assign step    = is_long ? STEP_LONG : STEP_WORD;
  assign dec_ptr = ptr - step;

  always_comb begin
    addr    = ptr;
    ptr_nxt = ptr;
    ptr_upd = 1'b1;
    unique case (mode)
      AM_PREDEC: begin
        addr    = dec_ptr;
        ptr_nxt = dec_ptr;
      end
      AM_PLAIN:   ptr_upd = 1'b0;
      AM_POSTINC: ptr_nxt = ptr + step;
      AM_POSTIDX: ptr_nxt = ptr + idx;
      default:    ptr_upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/xfer_ptrfile.sv
module xfer_ptrfile
  import dsp_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PTR_SEL_W-1:0] rsel,
  output logic [ADDR_W-1:0]    ptr_rd,
  output logic [ADDR_W-1:0]    idx_rd,
  input  logic                 upd_we,
  input  logic [PTR_SEL_W-1:0] upd_sel,
  input  logic [ADDR_W-1:0]    upd_val,
  input  logic                 ld_we,
  input  logic [PTR_SEL_W:0]   ld_sel,
  input  logic [ADDR_W-1:0]    ld_val
);

  logic [ADDR_W-1:0] ptr_q [NUM_PTR];
  logic [ADDR_W-1:0] idx_q [NUM_PTR];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_pair
    localparam logic [PTR_SEL_W-1:0] ID = PTR_SEL_W'(g);

    // Instruction writeback has priority over the side load.
    always_ff @(posedge clk) begin
      if (rst) begin
        ptr_q[g] <= '0;
      end else if (upd_we && (upd_sel == ID)) begin
        ptr_q[g] <= upd_val;
      end else if (ld_we && (ld_sel == {1'b0, ID})) begin
        ptr_q[g] <= ld_val;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[g] <= '0;
      end else if (ld_we && (ld_sel == {1'b1, ID})) begin
        idx_q[g] <= ld_val;
      end
    end
  end

  assign ptr_rd = ptr_q[rsel];
  assign idx_rd = idx_q[rsel];

endmodule

// File: rtl/xfer_datafile.sv
module xfer_datafile #(
  parameter int DATA_W    = 32,
  parameter int NUM_DREG  = 8,
  parameter int NUM_GUARD = 2,
  parameter int GUARD_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rsel,
  output logic [DATA_W-1:0] rd_val,  // guard values come out sign-extended
  input  logic              we,
  input  logic [3:0]        wsel,
  input  logic [DATA_W-1:0] wr_val   // guard writes keep the low bits only
);

  localparam int EXT_W = DATA_W - GUARD_W;

  logic [DATA_W-1:0]  dreg_q [NUM_DREG];
  logic [GUARD_W-1:0] greg_q [NUM_GUARD];

  for (genvar i = 0; i < NUM_DREG; i++) begin : g_dreg
    always_ff @(posedge clk) begin
      if (rst) begin
        dreg_q[i] <= '0;
      end else if (we && (wsel == 4'(i))) begin
        dreg_q[i] <= wr_val;
      end
    end
  end

  for (genvar j = 0; j < NUM_GUARD; j++) begin : g_greg
    always_ff @(posedge clk) begin
      if (rst) begin
        greg_q[j] <= '0;
      end else if (we && (wsel == 4'(NUM_DREG + j))) begin
        greg_q[j] <= wr_val[GUARD_W-1:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_DREG; i++) begin
      if (rsel == 4'(i)) rd_val = dreg_q[i];
    end
    for (int j = 0; j < NUM_GUARD; j++) begin
      if (rsel == 4'(NUM_DREG + j)) begin
        rd_val = {{EXT_W{greg_q[j][GUARD_W-1]}}, greg_q[j]};
      end
    end
  end

endmodule

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit
  import dsp_xfer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_DREG  = 8,
  parameter int NUM_GUARD = 2,
  parameter int GUARD_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_valid,
  input  logic [15:0]          instr,
  input  logic                 ld_we,
  input  logic [PTR_SEL_W:0]   ld_sel,
  input  logic [ADDR_W-1:0]    ld_val,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic                 mem_long,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 illegal
);

  localparam int HALF_W = DATA_W / 2;

  xfer_dec_t         dec;
  logic [ADDR_W-1:0] ptr_rd, idx_rd;
  logic [ADDR_W-1:0] agu_addr, agu_nxt;
  logic              agu_upd;
  logic [DATA_W-1:0] opnd_rd;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] ld_data;
  logic              go;
  logic              illegal_q;

  xfer_decode #(
    .NUM_DREG (NUM_DREG),
    .NUM_GUARD(NUM_GUARD)
  ) u_dec (
    .valid(instr_valid),
    .instr(instr),
    .dec  (dec)
  );

  assign go = dec.legal;

  xfer_ptrfile #(
    .ADDR_W(ADDR_W)
  ) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .rsel   (dec.psel),
    .ptr_rd (ptr_rd),
    .idx_rd (idx_rd),
    .upd_we (go && agu_upd),
    .upd_sel(dec.psel),
    .upd_val(agu_nxt),
    .ld_we  (ld_we),
    .ld_sel (ld_sel),
    .ld_val (ld_val)
  );

  xfer_agu #(
    .ADDR_W(ADDR_W)
  ) u_agu (
    .mode   (dec.mode),
    .is_long(dec.is_long),
    .ptr    (ptr_rd),
    .idx    (idx_rd),
    .addr   (agu_addr),
    .ptr_nxt(agu_nxt),
    .ptr_upd(agu_upd)
  );

  // Store lane formatting: guard values are already sign-extended.
  always_comb begin
    if (dec.guard || dec.is_long) begin
      st_data = opnd_rd;
    end else begin
      st_data = {{HALF_W{1'b0}}, opnd_rd[DATA_W-1:HALF_W]};
    end
  end

  // Load formatting: words go to the upper half, guards take raw low bits.
  always_comb begin
    if (dec.guard || dec.is_long) begin
      ld_data = mem_rdata;
    end else begin
      ld_data = {mem_rdata[HALF_W-1:0], {HALF_W{1'b0}}};
    end
  end

  xfer_datafile #(
    .DATA_W   (DATA_W),
    .NUM_DREG (NUM_DREG),
    .NUM_GUARD(NUM_GUARD),
    .GUARD_W  (GUARD_W)
  ) u_data (
    .clk   (clk),
    .rst   (rst),
    .rsel  (dec.dsel),
    .rd_val(opnd_rd),
    .we    (go && !dec.is_store),
    .wsel  (dec.dsel),
    .wr_val(ld_data)
  );

  assign mem_re    = go && !dec.is_store;
  assign mem_we    = go && dec.is_store;
  assign mem_long  = go && dec.is_long;
  assign mem_addr  = go ? agu_addr : '0;
  assign mem_wdata = mem_we ? st_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= dec.hit && !dec.legal;
    end
  end

  assign illegal = illegal_q;

endmodule

// File: rtl/dsp_xfer_unit_chk.sv
module dsp_xfer_unit_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_DREG  = 8,
  parameter int NUM_GUARD = 2,
  parameter int GUARD_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic [15:0]       instr,
  input logic              mem_re,
  input logic              mem_we,
  input logic              mem_long,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              illegal
);

  localparam int HALF_W = DATA_W / 2;

  logic opc_ok, code_guard, code_bad;
  assign opc_ok     = instr_valid && (instr[15:10] == 6'b111101);
  assign code_guard = ({28'd0, instr[7:4]} >= 32'(NUM_DREG)) &&
                      ({28'd0, instr[7:4]} <  32'(NUM_DREG + NUM_GUARD));
  assign code_bad   = {28'd0, instr[7:4]} >= 32'(NUM_DREG + NUM_GUARD);

  AST_NO_FOREIGN_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !opc_ok |-> (!mem_re && !mem_we)); // R1

  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (opc_ok && code_bad) |-> (!mem_re && !mem_we)); // R10

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(opc_ok && code_bad)); // R10

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (opc_ok && code_bad) |=> illegal); // R10

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we)); // R11

  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_long && !code_guard) |-> (mem_wdata[DATA_W-1:HALF_W] == '0)); // R7

  AST_GUARD_SEXT: assert property (@(posedge clk) disable iff (rst)
    (mem_we && code_guard) |->
      (mem_wdata[DATA_W-1:GUARD_W] == {(DATA_W-GUARD_W){mem_wdata[GUARD_W-1]}})); // R9

  AST_STORE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    (opc_ok && !code_bad && instr[0]) |-> (mem_we && !mem_re)); // R8

endmodule

bind dsp_xfer_unit dsp_xfer_unit_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_DREG (NUM_DREG),
  .NUM_GUARD(NUM_GUARD),
  .GUARD_W  (GUARD_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr_valid(instr_valid),
  .instr      (instr),
  .mem_re     (mem_re),
  .mem_we     (mem_we),
  .mem_long   (mem_long),
  .mem_wdata  (mem_wdata),
  .illegal    (illegal)
);

// File: tb/dsp_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module dsp_xfer_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr;
  logic        ld_we;
  logic [2:0]  ld_sel;
  logic [31:0] ld_val;
  logic [31:0] mem_addr;
  logic        mem_re, mem_we, mem_long;
  logic [31:0] mem_wdata, mem_rdata;
  logic        illegal;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2 clk = ~clk;   // 250 MHz

  // Memory model: upper half is a constant tag, lower half echoes the address.
  assign mem_rdata = {16'hC0DE, mem_addr[15:0]};

  dsp_xfer_unit dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .ld_we(ld_we), .ld_sel(ld_sel), .ld_val(ld_val),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_long(mem_long),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .illegal(illegal)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {req, instr, re, we, long, addr, wdata, illegal}
  localparam int NVEC = 23;
  localparam logic [87:0] VEC [NVEC] = '{
    {4'd7,  16'hF404, 3'b100, 32'h00000100, 32'h00000000, 1'b0}, // R7 word load D0
    {4'd7,  16'hF405, 3'b010, 32'h00000100, 32'h00000100, 1'b0}, // R7 word store D0
    {4'd5,  16'hF41A, 3'b101, 32'h00000100, 32'h00000000, 1'b0}, // R5 long load D1, P0+4
    {4'd8,  16'hF417, 3'b011, 32'h00000104, 32'hC0DE0100, 1'b0}, // R8 long store D1
    {4'd3,  16'hF513, 3'b011, 32'h000001FC, 32'hC0DE0100, 1'b0}, // R3 predec long
    {4'd3,  16'hF520, 3'b100, 32'h000001FA, 32'h00000000, 1'b0}, // R3 predec word load D2
    {4'd7,  16'hF529, 3'b010, 32'h000001FA, 32'h000001FA, 1'b0}, // R7 word store, P1+2
    {4'd5,  16'hF527, 3'b011, 32'h000001FC, 32'h01FA0000, 1'b0}, // R5 step of 2 seen
    {4'd6,  16'hF63E, 3'b101, 32'h000002E0, 32'h00000000, 1'b0}, // R6 indexed load D3
    {4'd2,  16'hF635, 3'b010, 32'h00000300, 32'h0000C0DE, 1'b0}, // R2 P2/D3 fields
    {4'd9,  16'hF596, 3'b101, 32'h000001FC, 32'h00000000, 1'b0}, // R9 load G1
    {4'd9,  16'hF484, 3'b100, 32'h00000104, 32'h00000000, 1'b0}, // R9 word load G0
    {4'd9,  16'hF495, 3'b010, 32'h00000104, 32'hFFFFFFFC, 1'b0}, // R9 store G1 negative
    {4'd9,  16'hF487, 3'b011, 32'h00000104, 32'h00000004, 1'b0}, // R9 store G0 positive
    {4'd6,  16'hF71F, 3'b011, 32'h00000008, 32'hC0DE0100, 1'b0}, // R6 P3 += -16
    {4'd6,  16'hF71B, 3'b011, 32'hFFFFFFF8, 32'hC0DE0100, 1'b0}, // R6 wrapped pointer
    {4'd6,  16'hF71B, 3'b011, 32'hFFFFFFFC, 32'hC0DE0100, 1'b0}, // R6 P3 wraps to 0
    {4'd3,  16'hF713, 3'b011, 32'hFFFFFFFC, 32'hC0DE0100, 1'b0}, // R3 predec wraps
    {4'd4,  16'hF715, 3'b010, 32'hFFFFFFFC, 32'h0000C0DE, 1'b0}, // R4 plain
    {4'd10, 16'hF4AA, 3'b000, 32'h00000000, 32'h00000000, 1'b0}, // R10 code 10
    {4'd10, 16'hF417, 3'b011, 32'h00000104, 32'hC0DE0100, 1'b1}, // R10 flag, P0 kept
    {4'd1,  16'hE41A, 3'b000, 32'h00000000, 32'h00000000, 1'b0}, // R1 foreign opcode
    {4'd1,  16'hF417, 3'b011, 32'h00000104, 32'hC0DE0100, 1'b0}  // R1 P0/D1 kept
  };

  task automatic ld(input logic [2:0] sel, input logic [31:0] val);
    ld_we = 1'b1; ld_sel = sel; ld_val = val;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = 16'h0;
    ld_we = 1'b0; ld_sel = 3'd0; ld_val = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R12", "illegal after reset", {31'd0, illegal}, 32'd0);
    check("R12", "strobes idle in reset", {30'd0, mem_re, mem_we}, 32'd0);
    rst = 1'b0;

    // Cleared state: plain store of D0 through P0.
    instr_valid = 1'b1; instr = 16'hF405;
    #1;
    check("R12", "addr from cleared P0", mem_addr, 32'h0);
    check("R12", "wdata from cleared D0", mem_wdata, 32'h0);
    @(negedge clk);
    instr_valid = 1'b0;

    ld(3'd0, 32'h00000100);
    ld(3'd1, 32'h00000200);
    ld(3'd2, 32'h000002E0);
    ld(3'd3, 32'h00000008);
    ld(3'd4, 32'h00000040);
    ld(3'd5, 32'h00000040);
    ld(3'd6, 32'h00000020);
    ld(3'd7, 32'hFFFFFFF0);

    for (int k = 0; k < NVEC; k++) begin
      logic [87:0] v;
      string       tag;
      v   = VEC[k];
      tag = $sformatf("R%0d", v[87:84]);
      instr_valid = 1'b1;
      instr       = v[83:68];
      #1;
      check(tag, $sformatf("vec%0d mem_re", k), {31'd0, mem_re}, {31'd0, v[67]});
      check(tag, $sformatf("vec%0d mem_we", k), {31'd0, mem_we}, {31'd0, v[66]});
      check(tag, $sformatf("vec%0d illegal", k), {31'd0, illegal}, {31'd0, v[0]});
      if (v[67] || v[66]) begin
        check(tag, $sformatf("vec%0d mem_long", k), {31'd0, mem_long}, {31'd0, v[65]});
        check(tag, $sformatf("vec%0d mem_addr", k), mem_addr, v[64:33]);
      end
      if (v[66]) begin
        check(tag, $sformatf("vec%0d mem_wdata", k), mem_wdata, v[32:1]);
      end
      @(negedge clk);
    end

    // R1/R11: a transfer word without valid does nothing.
    instr_valid = 1'b0; instr = 16'hF41A;
    #1;
    check("R11", "no strobe without valid", {30'd0, mem_re, mem_we}, 32'd0);
    @(negedge clk);
    instr_valid = 1'b1; instr = 16'hF417;
    #1;
    check("R1", "P0 unchanged after invalid slot", mem_addr, 32'h00000104);
    check("R11", "illegal stays low", {31'd0, illegal}, 32'd0);
    @(negedge clk);

    // R12: side load of a pointer is seen by the next access.
    instr_valid = 1'b0;
    ld(3'd0, 32'h00001000);
    instr_valid = 1'b1; instr = 16'hF417;
    #1;
    check("R12", "side-loaded P0", mem_addr, 32'h00001000);
    @(negedge clk);
    instr_valid = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule